// File: doc/BRIEF.md
# Aperture Address Remapper

This block sits in front of one master port of an on-chip interconnect and rewrites every read and write address before the interconnect sees it. The 4 GB address space is cut into sixteen 256 MB apertures, picked by the top address nibble. Each aperture carries two programmable values:

- a 4-bit target slave number, which is sent alongside the forwarded address;
- a 4-bit replacement nibble, which takes the place of the aperture index in the forwarded address.

A slave number of zero marks an aperture as unmapped. Such an access is not forwarded. The request is accepted locally and flagged as a decode error.

Software programs the table through four 32-bit staging registers. The new contents take effect only after a 1 is written to a separate commit register. The commit is held back while either address channel has a request waiting on the downstream ready. A stalled request therefore never sees its translation change.

Top module: `aperture_remap`

## Requirements
- R1: The aperture index is address bits [31:28]. A forwarded request carries, on its slave output, the active slave number of that aperture.
- R2: The forwarded address is the aperture's active replacement nibble in bits [31:28], followed by input bits [27:0] unchanged.
- R3: Staging register layout, with aperture i in nibble [4i+3:4i] of its word:
  - byte offset 0x0 holds the slave numbers of apertures 0 to 7;
  - byte offset 0x4 holds the slave numbers of apertures 8 to 15;
  - byte offset 0x8 holds the replacement nibbles of apertures 0 to 7;
  - byte offset 0xC holds the replacement nibbles of apertures 8 to 15.
- R4: Writes to the staging registers do not change translation. Writing a value with bit 0 set to the commit register at byte offset 0x10 copies the whole staged table into the active table. The copy happens at the second rising edge after the write, provided no channel is stalled.
- R5: A request to an aperture whose active slave number is 0 gives:
  - output valid low;
  - input ready high;
  - a decode-error pulse in the same cycle.
- R6: A request to a mapped aperture has output valid equal to input valid, and input ready equal to output ready.
- R7: While either channel holds valid high with ready low, a pending commit is deferred. The active table does not change until no channel is stalled.
- R8: Reads return the staged words, and the commit register reads as 0. After reset, every staged and active entry is 0, so all apertures are unmapped.
- R9: The read and write address channels are translated independently through the same active table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| ar_in_valid | input | 1 | Read request valid from master |
| ar_in_addr | input | 32 | Read request address from master |
| ar_in_ready | output | 1 | Read request accepted |
| ar_out_valid | output | 1 | Forwarded read request valid |
| ar_out_addr | output | 32 | Rewritten read address |
| ar_out_slave | output | 4 | Target slave number for read |
| ar_out_ready | input | 1 | Downstream read ready |
| ar_decerr | output | 1 | Read request hit an unmapped aperture |
| aw_in_valid | input | 1 | Write request valid from master |
| aw_in_addr | input | 32 | Write request address from master |
| aw_in_ready | output | 1 | Write request accepted |
| aw_out_valid | output | 1 | Forwarded write request valid |
| aw_out_addr | output | 32 | Rewritten write address |
| aw_out_slave | output | 4 | Target slave number for write |
| aw_out_ready | input | 1 | Downstream write ready |
| aw_decerr | output | 1 | Write request hit an unmapped aperture |

## Verification
The bench builds the block with its default 32-bit address width. With that width all sixteen apertures can be reached, and both address extremes, 0x0000_0000-class and 0xFFFF_FFFF, land on the first and last apertures. A programmed map that mixes mapped and unmapped apertures, in both halves of the table, is walked on both channels at once. Directed steps then cover the reset state, readback, the delay before a commit takes effect, and a commit issued while a read request is stalled.

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              ar_in_valid,
  input  logic [ADDR_W-1:0] ar_in_addr,
  output logic              ar_in_ready,
  output logic              ar_out_valid,
  output logic [ADDR_W-1:0] ar_out_addr,
  output logic [3:0]        ar_out_slave,
  input  logic              ar_out_ready,
  output logic              ar_decerr,
  input  logic              aw_in_valid,
  input  logic [ADDR_W-1:0] aw_in_addr,
  output logic              aw_in_ready,
  output logic              aw_out_valid,
  output logic [ADDR_W-1:0] aw_out_addr,
  output logic [3:0]        aw_out_slave,
  input  logic              aw_out_ready,
  output logic              aw_decerr
);
  localparam int NIB   = 4;
  localparam int NAPER = 1 << NIB;
  localparam int TBL_W = NAPER * NIB;
  localparam int LOW_W = ADDR_W - NIB;

  logic [TBL_W-1:0] sel_stg, off_stg, sel_act, off_act;
  logic             pending;
  logic [2:0]       widx;

  assign widx = cfg_addr[4:2];

  function automatic logic [NIB-1:0] pick(input logic [TBL_W-1:0] t, input logic [NIB-1:0] i);
    return t[i*NIB +: NIB];
  endfunction

  logic [NIB-1:0] ar_idx, aw_idx;
  logic           ar_hit, aw_hit, ar_stall, aw_stall;

  assign ar_idx       = ar_in_addr[ADDR_W-1 -: NIB];
  assign aw_idx       = aw_in_addr[ADDR_W-1 -: NIB];
  assign ar_out_slave = pick(sel_act, ar_idx);
  assign aw_out_slave = pick(sel_act, aw_idx);
  assign ar_hit       = ar_out_slave != '0;
  assign aw_hit       = aw_out_slave != '0;
  assign ar_out_addr  = {pick(off_act, ar_idx), ar_in_addr[LOW_W-1:0]};
  assign aw_out_addr  = {pick(off_act, aw_idx), aw_in_addr[LOW_W-1:0]};
  assign ar_out_valid = ar_in_valid & ar_hit;
  assign aw_out_valid = aw_in_valid & aw_hit;
  assign ar_in_ready  = ar_hit ? ar_out_ready : 1'b1;
  assign aw_in_ready  = aw_hit ? aw_out_ready : 1'b1;
  assign ar_decerr    = ar_in_valid & ~ar_hit;
  assign aw_decerr    = aw_in_valid & ~aw_hit;
  assign ar_stall     = ar_in_valid & ~ar_in_ready;
  assign aw_stall     = aw_in_valid & ~aw_in_ready;

  always_comb begin
    case (widx)
      3'd0:    cfg_rdata = sel_stg[31:0];
      3'd1:    cfg_rdata = sel_stg[63:32];
      3'd2:    cfg_rdata = off_stg[31:0];
      3'd3:    cfg_rdata = off_stg[63:32];
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_stg <= '0;
      off_stg <= '0;
    end else if (cfg_we) begin
      case (widx)
        3'd0:    sel_stg[31:0]  <= cfg_wdata;
        3'd1:    sel_stg[63:32] <= cfg_wdata;
        3'd2:    off_stg[31:0]  <= cfg_wdata;
        3'd3:    off_stg[63:32] <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_act <= '0;
      off_act <= '0;
      pending <= 1'b0;
    end else begin
      if (pending && !ar_stall && !aw_stall) begin
        sel_act <= sel_stg;
        off_act <= off_stg;
        pending <= 1'b0;
      end
      if (cfg_we && widx == 3'd4 && cfg_wdata[0])
        pending <= 1'b1;
    end
  end

  assert_fwd_mapped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_out_valid |-> ar_out_slave != '0) and (aw_out_valid |-> aw_out_slave != '0));

  assert_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ar_decerr && ar_out_valid) && !(aw_decerr && aw_out_valid));

  assert_map_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_stall || aw_stall) |=> ($stable(sel_act) && $stable(off_act)));

  assert_low_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ar_out_valid |-> ar_out_addr[LOW_W-1:0] == ar_in_addr[LOW_W-1:0]);

  assert_commit_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending) |=> ($stable(sel_act) && $stable(off_act)));

  assert_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ar_out_valid |-> ar_in_ready == ar_out_ready);
endmodule

// File: tb/aperture_remap_tb_top.sv
module aperture_remap_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic ar_in_valid = 0, ar_in_ready, ar_out_valid, ar_out_ready = 1, ar_decerr;
  logic [31:0] ar_in_addr = '0, ar_out_addr;
  logic [3:0] ar_out_slave;
  logic aw_in_valid = 0, aw_in_ready, aw_out_valid, aw_out_ready = 1, aw_decerr;
  logic [31:0] aw_in_addr = '0, aw_out_addr;
  logic [3:0] aw_out_slave;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  aperture_remap dut_i (.*);

  // {in_addr, mapped, slave, out_addr}
  localparam logic [68:0] VEC [0:9] = '{
    {32'h0123_4567, 1'b1, 4'd1, 32'h8123_4567},
    {32'h1FFF_FFFF, 1'b1, 4'd2, 32'h9FFF_FFFF},
    {32'h2000_0000, 1'b1, 4'd3, 32'hA000_0000},
    {32'h3000_0010, 1'b0, 4'd0, 32'h0},
    {32'h8ABC_DEF0, 1'b1, 4'd4, 32'hCABC_DEF0},
    {32'h9000_0001, 1'b1, 4'd5, 32'hD000_0001},
    {32'hA123_0000, 1'b0, 4'd0, 32'h0},
    {32'hD765_4321, 1'b1, 4'd7, 32'hE765_4321},
    {32'hE000_0000, 1'b0, 4'd0, 32'h0},
    {32'hFFFF_FFFF, 1'b1, 4'd6, 32'hFFFF_FFFF}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); cfg_addr = a; #1;
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: reset state
    rd(5'h00, 32'h0, "R8 reset sel lo");
    rd(5'h0C, 32'h0, "R8 reset off hi");
    @(negedge clk); ar_in_valid = 1; ar_in_addr = 32'h0123_4567; #1;
    chk(ar_decerr && !ar_out_valid && ar_in_ready, "R8 R5 reset unmapped", {ar_decerr, ar_out_valid, ar_in_ready}, 3'b101);
    ar_in_valid = 0;

    // R3: staging layout
    wr(5'h00, 32'h0000_0321);
    wr(5'h04, 32'h6070_0054);
    wr(5'h08, 32'h0000_0A98);
    wr(5'h0C, 32'hF0E0_00DC);
    rd(5'h00, 32'h0000_0321, "R3 sel lo readback");
    rd(5'h04, 32'h6070_0054, "R3 sel hi readback");
    rd(5'h08, 32'h0000_0A98, "R3 off lo readback");
    rd(5'h0C, 32'hF0E0_00DC, "R3 off hi readback");

    // R4: no effect before commit
    @(negedge clk); ar_in_valid = 1; ar_in_addr = 32'h0123_4567; #1;
    chk(ar_decerr && !ar_out_valid, "R4 staged not active", {ar_decerr, ar_out_valid}, 2'b10);
    ar_in_valid = 0;
    wr(5'h10, 32'h1);
    rd(5'h10, 32'h0, "R8 commit reads zero");

    // R1 R2 R5 R6 R9: vector walk on both channels
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ar_in_valid = 1; ar_in_addr = VEC[i][68:37];
      aw_in_valid = 1; aw_in_addr = VEC[i][68:37];
      #1;
      chk(ar_out_valid == VEC[i][36], "R1 R5 ar valid", {31'b0, ar_out_valid}, {31'b0, VEC[i][36]});
      chk(ar_decerr == !VEC[i][36] && ar_in_ready, "R5 R6 ar err/ready", {30'b0, ar_decerr, ar_in_ready}, {30'b0, !VEC[i][36], 1'b1});
      chk(aw_out_valid == VEC[i][36] && aw_decerr == !VEC[i][36], "R9 aw valid/err", {30'b0, aw_out_valid, aw_decerr}, {30'b0, VEC[i][36], !VEC[i][36]});
      if (VEC[i][36]) begin
        chk(ar_out_slave == VEC[i][35:32], "R1 ar slave", {28'b0, ar_out_slave}, {28'b0, VEC[i][35:32]});
        chk(ar_out_addr == VEC[i][31:0], "R2 ar addr", ar_out_addr, VEC[i][31:0]);
        chk(aw_out_slave == VEC[i][35:32] && aw_out_addr == VEC[i][31:0], "R9 aw translation", aw_out_addr, VEC[i][31:0]);
      end
    end
    ar_in_valid = 0; aw_in_valid = 0;

    // R6 R7: commit deferred during stall
    @(negedge clk); ar_out_ready = 0; ar_in_valid = 1; ar_in_addr = 32'h0123_4567; #1;
    chk(!ar_in_ready && ar_out_valid, "R6 ready follows downstream", {31'b0, ar_in_ready}, 32'h0);
    wr(5'h00, 32'h0000_0325);
    wr(5'h10, 32'h1);
    repeat (3) @(negedge clk);
    #1;
    chk(ar_out_slave == 4'd1, "R7 map held during stall", {28'b0, ar_out_slave}, 32'h1);
    @(negedge clk); ar_out_ready = 1;
    @(negedge clk); ar_in_valid = 0;
    @(negedge clk); ar_in_valid = 1; #1;
    chk(ar_out_slave == 4'd5 && ar_out_addr == 32'h8123_4567, "R7 commit after stall", {28'b0, ar_out_slave}, 32'h5);
    ar_in_valid = 0;

    // R4: commit with bit0 clear does nothing
    wr(5'h00, 32'h0000_0320);
    wr(5'h10, 32'h2);
    repeat (2) @(negedge clk);
    ar_in_valid = 1; #1;
    chk(ar_out_slave == 4'd5 && ar_out_valid, "R4 bit0 clear ignored", {28'b0, ar_out_slave}, 32'h5);
    ar_in_valid = 0;
    wr(5'h10, 32'h1);
    @(negedge clk); ar_in_valid = 1; #1;
    chk(ar_decerr && !ar_out_valid, "R4 R5 aperture now unmapped", {31'b0, ar_decerr}, 32'h1);
    ar_in_valid = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule